// File: doc/BRIEF.md
# Call and Jump Target Unit

This block resolves the unconditional control-transfer instructions of a 32-bit instruction set whose compact branches have no delay slot. It takes one instruction word per cycle, the address of that instruction, and one register value. From these it produces the address of the next instruction, a redirect flag, a link write and a second register write. The register-file read index goes out combinationally on `rd_idx_o`. The surrounding pipeline must return that register's value on `rd_val_i` in the same cycle.

Five forms are handled:
- a long PC-relative branch, with or without a link;
- a combined register move and PC-relative call;
- a jump through a register, in plain form and in its hazard-barrier variant;
- a register-relative call, whose target is the return address plus twice the register value.

All results are registered and appear one cycle after the instruction is presented. The block does not store registers. It does not act on the hazard barrier. A code in the register-jump group that is not assigned raises a reserved-instruction flag.

Top module: `jt_unit`

## Requirements
- R1: The results appear one clock after `valid_i`. `vld_o` is high exactly in the cycle after a cycle with `valid_i` high. While `vld_o` is low, `take_o`, `lnk_we_o`, `mv_we_o` and `rsvd_o` are all low, and synchronous reset drives them all low.
- R2: Long form, opcode bits 31:26 = 0x0A. The offset is sign-extended from its bit 25. Offset bit 25 is instruction bit 0, offset bits 24:1 are instruction bits 24:1, and offset bit 0 is zero. The target is PC+4+offset. Instruction bit 25 = 0 gives a plain branch with no link. Bit 25 = 1 also writes PC+4 to register 31.
- R3: Move-and-call form, opcode = 0x02. The offset is sign-extended from its bit 21. Offset bit 21 is instruction bit 0, offset bits 20:1 are instruction bits 20:1, and offset bit 0 is zero. The target is PC+4+offset, and PC+4 is written to register 31. In the same result, the move port writes `rd_val_i` to register 4 when bit 24 is 0, or to register 5 when bit 24 is 1.
- R4: The 4-bit move selector is {bit 25, bits 23:21}. It maps as follows: 0..7 to registers 16..23, 8..10 to registers 8..10, 11 to register 0, and 12..15 to registers 4..7. The mapped index is driven on `rd_idx_o`.
- R5: Register-jump group, opcode = 0x12, with sub-code in bits 15:12 equal to 0, or to 1 (the barrier variant). The next PC is the value of the register whose index is in bits 20:16; that index is driven on `rd_idx_o`. PC+4 is written to the register indexed by bits 25:21 only when that index is nonzero.
- R6: Register-jump group with sub-code 8. The target is PC+4 plus the register value shifted left by one, wrapping modulo 2^W. The link rule is the same as in R5.
- R7: In the register-jump group, any other sub-code sets `rsvd_o`. `take_o` stays low, `npc_o` is PC+4, and no write is made.
- R8: Any other opcode gives `take_o` low, `npc_o` = PC+4, no writes and `rsvd_o` low. For such an opcode `rd_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction present |
| insn_i | input | 32 | Instruction word |
| pc_i | input | W | Address of the instruction |
| rd_val_i | input | W | Value of register `rd_idx_o`, same cycle |
| rd_idx_o | output | 5 | Register read index (combinational) |
| vld_o | output | 1 | Result valid |
| take_o | output | 1 | Control transfer taken |
| npc_o | output | W | Next instruction address |
| lnk_we_o | output | 1 | Link write enable |
| lnk_idx_o | output | 5 | Link destination register |
| lnk_val_o | output | W | Link value (PC+4) |
| mv_we_o | output | 1 | Move write enable |
| mv_idx_o | output | 5 | Move destination register |
| mv_val_o | output | W | Move value |
| rsvd_o | output | 1 | Reserved-instruction exception |

## Verification
The checker assumes that `rd_val_i` is the register-file value of `rd_idx_o` in the same cycle, and that register 0 reads as zero. It also assumes that `pc_i` is stable while `valid_i` is high. The bench meets the first two assumptions by modelling the register file combinationally from `rd_idx_o`. That model returns zero for index 0 and a per-instruction scrambled value otherwise. The bench drives each instruction for one cycle and checks the registered result at the next falling edge. Random instructions are drawn only from the five assigned forms, the reserved sub-codes and unrelated opcodes.

// File: rtl/jt_pkg.sv
package jt_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_BRANCH, K_CALL, K_MVCALL, K_JREG, K_RELCALL, K_RSVD
  } jt_kind_e;

  localparam logic [5:0] OP_LONG   = 6'h0A;
  localparam logic [5:0] OP_MVCALL = 6'h02;
  localparam logic [5:0] OP_RJUMP  = 6'h12;
  localparam logic [3:0] SUB_JREG    = 4'h0;
  localparam logic [3:0] SUB_JREG_HB = 4'h1;
  localparam logic [3:0] SUB_REL     = 4'h8;
  localparam int        IDX_W      = 5;
  localparam logic [IDX_W-1:0] LINK_REG = 5'd31;
endpackage

// File: rtl/jt_decode.sv
module jt_decode
  import jt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [31:0]      insn,
  output jt_kind_e         kind,
  output logic [IDX_W-1:0] rs_f,
  output logic [IDX_W-1:0] rt_f,
  output logic [IDX_W-1:0] mv_dst,
  output logic [3:0]       mv_sel,
  output logic [W-1:0]     disp
);
  localparam int EXT_LONG = W - 26;
  localparam int EXT_MV   = W - 22;

  logic [5:0] op;
  logic [3:0] sub;
  logic [W-1:0] disp_long, disp_mv;

  assign op  = insn[31:26];
  assign sub = insn[15:12];
  assign rt_f = insn[25:21];
  assign rs_f = insn[20:16];
  assign mv_dst = insn[24] ? 5'd5 : 5'd4;
  assign mv_sel = {insn[25], insn[23:21]};
  assign disp_long = {{EXT_LONG{insn[0]}}, insn[0], insn[24:1], 1'b0};
  assign disp_mv   = {{EXT_MV{insn[0]}}, insn[0], insn[20:1], 1'b0};

  always_comb begin
    kind = K_NONE;
    disp = disp_long;
    unique case (op)
      OP_LONG:   kind = insn[25] ? K_CALL : K_BRANCH;
      OP_MVCALL: begin
        kind = K_MVCALL;
        disp = disp_mv;
      end
      OP_RJUMP: begin
        if (sub == SUB_JREG || sub == SUB_JREG_HB) kind = K_JREG;
        else if (sub == SUB_REL)                   kind = K_RELCALL;
        else                                       kind = K_RSVD;
      end
      default: kind = K_NONE;
    endcase
  end

  logic unused_ok;
  assign unused_ok = ^insn[11:0];
endmodule

// File: rtl/jt_srcmap.sv
module jt_srcmap
  import jt_pkg::*;
(
  input  logic [3:0]       sel,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    if (sel < 4'd8)        idx = {1'b1, 1'b0, sel[2:0]};
    else if (sel < 4'd11)  idx = {1'b0, sel};
    else if (sel == 4'd11) idx = '0;
    else                   idx = {1'b0, 2'b01, sel[1:0]};
  end
endmodule

// File: rtl/jt_target.sv
module jt_target
  import jt_pkg::*;
#(
  parameter int W = 32
) (
  input  jt_kind_e     kind,
  input  logic [W-1:0] pc4,
  input  logic [W-1:0] disp,
  input  logic [W-1:0] reg_val,
  output logic [W-1:0] npc,
  output logic         take
);
  always_comb begin
    npc  = pc4;
    take = 1'b1;
    unique case (kind)
      K_BRANCH, K_CALL, K_MVCALL: npc = pc4 + disp;
      K_JREG:                     npc = reg_val;
      K_RELCALL:                  npc = pc4 + {reg_val[W-2:0], 1'b0};
      default:                    take = 1'b0;
    endcase
  end
endmodule

// File: rtl/jt_unit.sv
module jt_unit
  import jt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [31:0]      insn_i,
  input  logic [W-1:0]     pc_i,
  input  logic [W-1:0]     rd_val_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             vld_o,
  output logic             take_o,
  output logic [W-1:0]     npc_o,
  output logic             lnk_we_o,
  output logic [IDX_W-1:0] lnk_idx_o,
  output logic [W-1:0]     lnk_val_o,
  output logic             mv_we_o,
  output logic [IDX_W-1:0] mv_idx_o,
  output logic [W-1:0]     mv_val_o,
  output logic             rsvd_o
);
  jt_kind_e         kind;
  logic [IDX_W-1:0] rs_f, rt_f, mv_dst, mv_src;
  logic [3:0]       mv_sel;
  logic [W-1:0]     disp, pc4, npc_c;
  logic             take_c, lwe_c, mwe_c;
  logic [IDX_W-1:0] lidx_c;

  jt_decode #(.W(W)) u_dec (
    .insn(insn_i), .kind(kind), .rs_f(rs_f), .rt_f(rt_f),
    .mv_dst(mv_dst), .mv_sel(mv_sel), .disp(disp)
  );

  jt_srcmap u_map (.sel(mv_sel), .idx(mv_src));

  assign pc4 = pc_i + W'(4);

  jt_target #(.W(W)) u_tgt (
    .kind(kind), .pc4(pc4), .disp(disp), .reg_val(rd_val_i),
    .npc(npc_c), .take(take_c)
  );

  always_comb begin
    rd_idx_o = '0;
    lwe_c    = 1'b0;
    lidx_c   = LINK_REG;
    mwe_c    = 1'b0;
    unique case (kind)
      K_CALL: lwe_c = 1'b1;
      K_MVCALL: begin
        lwe_c    = 1'b1;
        mwe_c    = 1'b1;
        rd_idx_o = mv_src;
      end
      K_JREG, K_RELCALL: begin
        rd_idx_o = rs_f;
        lidx_c   = rt_f;
        lwe_c    = (rt_f != '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o     <= 1'b0;
      take_o    <= 1'b0;
      npc_o     <= '0;
      lnk_we_o  <= 1'b0;
      lnk_idx_o <= '0;
      lnk_val_o <= '0;
      mv_we_o   <= 1'b0;
      mv_idx_o  <= '0;
      mv_val_o  <= '0;
      rsvd_o    <= 1'b0;
    end else begin
      vld_o     <= valid_i;
      take_o    <= valid_i && take_c;
      npc_o     <= npc_c;
      lnk_we_o  <= valid_i && lwe_c;
      lnk_idx_o <= lidx_c;
      lnk_val_o <= pc4;
      mv_we_o   <= valid_i && mwe_c;
      mv_idx_o  <= mv_dst;
      mv_val_o  <= rd_val_i;
      rsvd_o    <= valid_i && (kind == K_RSVD);
    end
  end
endmodule

// File: rtl/jt_unit_chk.sv
module jt_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         valid_i,
  input logic [W-1:0] pc_i,
  input logic         vld_o,
  input logic         take_o,
  input logic         lnk_we_o,
  input logic [4:0]   lnk_idx_o,
  input logic [W-1:0] lnk_val_o,
  input logic         mv_we_o,
  input logic [4:0]   mv_idx_o,
  input logic         rsvd_o
);
  assert_valid_lat_R1: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> vld_o);
  assert_idle_lat_R1: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !vld_o);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !vld_o |-> !take_o && !lnk_we_o && !mv_we_o && !rsvd_o);
  // Every link form writes PC+4 (R2, R3, R5, R6)
  assert_link_val_R2: assert property (@(posedge clk) disable iff (rst)
    lnk_we_o |-> lnk_val_o == $past(pc_i) + W'(4));
  assert_mv_pairs_call_R3: assert property (@(posedge clk) disable iff (rst)
    mv_we_o |-> lnk_we_o && lnk_idx_o == 5'd31 && take_o
               && (mv_idx_o == 5'd4 || mv_idx_o == 5'd5));
  assert_link_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    lnk_we_o |-> lnk_idx_o != 5'd0);
  assert_rsvd_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    rsvd_o |-> !take_o && !lnk_we_o && !mv_we_o);
endmodule

bind jt_unit jt_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .pc_i(pc_i), .vld_o(vld_o),
  .take_o(take_o), .lnk_we_o(lnk_we_o), .lnk_idx_o(lnk_idx_o),
  .lnk_val_o(lnk_val_o), .mv_we_o(mv_we_o), .mv_idx_o(mv_idx_o),
  .rsvd_o(rsvd_o)
);

// File: tb/jt_unit_tb.sv
module jt_unit_tb;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [W-1:0] pc_i = '0;
  logic [W-1:0] rd_val_i;
  logic [4:0] rd_idx_o, lnk_idx_o, mv_idx_o;
  logic vld_o, take_o, lnk_we_o, mv_we_o, rsvd_o;
  logic [W-1:0] npc_o, lnk_val_o, mv_val_o;
  logic [W-1:0] rf_base = 32'h1234_5678;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [W-1:0] regval(input logic [4:0] idx, input logic [W-1:0] b);
    return (idx == 5'd0) ? '0 : (b ^ ({27'd0, idx} * 32'h9E37_79B1));
  endfunction

  assign rd_val_i = regval(rd_idx_o, rf_base);

  jt_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i), .pc_i(pc_i),
    .rd_val_i(rd_val_i), .rd_idx_o(rd_idx_o), .vld_o(vld_o), .take_o(take_o),
    .npc_o(npc_o), .lnk_we_o(lnk_we_o), .lnk_idx_o(lnk_idx_o),
    .lnk_val_o(lnk_val_o), .mv_we_o(mv_we_o), .mv_idx_o(mv_idx_o),
    .mv_val_o(mv_val_o), .rsvd_o(rsvd_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] map_src(input logic [3:0] s);
    if (s <= 4'd7) return 5'd16 + 5'(s);
    if (s <= 4'd10) return 5'(s);
    if (s == 4'd11) return 5'd0;
    return 5'(s) - 5'd8;
  endfunction

  // Expected outputs computed from the requirement text
  task automatic run(input string req, input logic [31:0] ins, input logic [W-1:0] pc);
    logic [W-1:0] pc4, e_npc, rv, off;
    logic e_take, e_lwe, e_mwe, e_rsvd;
    logic [4:0] e_lidx, e_midx, e_ridx;
    logic [W-1:0] e_mval;
    pc4 = pc + 32'd4;
    e_npc = pc4; e_take = 0; e_lwe = 0; e_mwe = 0; e_rsvd = 0;
    e_lidx = 0; e_midx = 0; e_ridx = 0; e_mval = 0;
    @(negedge clk);
    rf_base = $urandom;
    if (ins[31:26] == 6'h0A) begin                         // R2
      off = {{6{ins[0]}}, ins[0], ins[24:1], 1'b0};
      e_take = 1; e_npc = pc4 + off;
      e_lwe = ins[25]; e_lidx = 5'd31;
    end else if (ins[31:26] == 6'h02) begin                // R3, R4
      off = {{10{ins[0]}}, ins[0], ins[20:1], 1'b0};
      e_take = 1; e_npc = pc4 + off; e_lwe = 1; e_lidx = 5'd31;
      e_ridx = map_src({ins[25], ins[23:21]});
      e_mwe = 1; e_midx = ins[24] ? 5'd5 : 5'd4;
      e_mval = regval(e_ridx, rf_base);
    end else if (ins[31:26] == 6'h12) begin
      rv = regval(ins[20:16], rf_base);
      if (ins[15:12] == 4'h0 || ins[15:12] == 4'h1) begin  // R5
        e_take = 1; e_npc = rv; e_ridx = ins[20:16];
        e_lwe = ins[25:21] != 0; e_lidx = ins[25:21];
      end else if (ins[15:12] == 4'h8) begin               // R6
        e_take = 1; e_npc = pc4 + (rv << 1); e_ridx = ins[20:16];
        e_lwe = ins[25:21] != 0; e_lidx = ins[25:21];
      end else e_rsvd = 1;                                 // R7
    end
    insn_i = ins; pc_i = pc; valid_i = 1'b1;
    #1;
    chk(req, "rd_idx", W'(rd_idx_o), W'(e_ridx));
    @(negedge clk);
    valid_i = 1'b0;
    chk("R1", "vld", W'(vld_o), 1);
    chk(req, "take", W'(take_o), W'(e_take));
    chk(req, "rsvd", W'(rsvd_o), W'(e_rsvd));
    chk(req, "lnk_we", W'(lnk_we_o), W'(e_lwe));
    chk(req, "mv_we", W'(mv_we_o), W'(e_mwe));
    if (!e_rsvd) chk(req, "npc", npc_o, e_npc);
    else chk("R7", "npc", npc_o, pc4);
    if (e_lwe) begin
      chk(req, "lnk_idx", W'(lnk_idx_o), W'(e_lidx));
      chk(req, "lnk_val", lnk_val_o, pc4);
    end
    if (e_mwe) begin
      chk(req, "mv_idx", W'(mv_idx_o), W'(e_midx));
      chk(req, "mv_val", mv_val_o, e_mval);
    end
  endtask

  function automatic logic [31:0] i_long(input logic lk, input logic [25:0] off);
    return {6'h0A, lk, off[24:1], off[25]};
  endfunction
  function automatic logic [31:0] i_mv(input logic [3:0] s, input logic d, input logic [21:0] off);
    return {6'h02, s[3], d, s[2:0], off[20:1], off[21]};
  endfunction
  function automatic logic [31:0] i_rj(input logic [4:0] rt, input logic [4:0] rs, input logic [3:0] sub);
    return {6'h12, rt, rs, sub, 12'h5A3};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1", "reset vld", W'(vld_o), 0);
    chk("R1", "reset take", W'(take_o), 0);
    chk("R1", "reset writes", W'({lnk_we_o, mv_we_o, rsvd_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "idle vld", W'(vld_o), 0);
    // directed corners
    run("R2", i_long(1'b0, 26'h200_0000), 32'h0000_1000);    // most negative
    run("R2", i_long(1'b1, 26'h1FF_FFFE), 32'h8000_0000);    // most positive call
    run("R2", i_long(1'b1, 26'h3FF_FFFE), 32'h0000_0000);    // -2 wraps
    run("R3", i_mv(4'd11, 1'b0, 22'h20_0000), 32'h0040_0000); // reg 0 source
    run("R4", i_mv(4'd12, 1'b1, 22'h00_0010), 32'h0000_2000);
    run("R4", i_mv(4'd7,  1'b1, 22'h1F_FFFE), 32'h0000_3000);
    run("R4", i_mv(4'd8,  1'b0, 22'h3F_FFFE), 32'h0000_3000);
    run("R4", i_mv(4'd15, 1'b0, 22'h00_0002), 32'h0000_3000);
    run("R5", i_rj(5'd0,  5'd9, 4'h0), 32'h0000_4000);       // no link
    run("R5", i_rj(5'd31, 5'd3, 4'h1), 32'h0000_4000);       // barrier variant
    run("R5", i_rj(5'd7,  5'd0, 4'h0), 32'h0000_4000);       // jump to zero
    run("R6", i_rj(5'd0,  5'd12, 4'h8), 32'hFFFF_FFF0);      // wraps, no link
    run("R6", i_rj(5'd2,  5'd0,  4'h8), 32'h0000_5000);
    run("R7", i_rj(5'd31, 5'd4, 4'h3), 32'h0000_6000);
    run("R7", i_rj(5'd1,  5'd4, 4'hF), 32'h0000_6000);
    run("R8", 32'hFC00_0001, 32'h0000_7000);
    run("R8", {6'h0B, 26'h3FF_FFFF}, 32'h0000_7000);
    @(negedge clk);
    chk("R1", "idle after op", W'({vld_o, take_o, lnk_we_o, mv_we_o}), 0);
    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      logic [W-1:0] pc;
      r = $urandom;
      pc = {$urandom} & 32'hFFFF_FFFE;
      case ($urandom % 6)
        0: run("R2", {6'h0A, r[25:0]}, pc);
        1: run("R3", {6'h02, r[25:0]}, pc);
        2: run("R5", {6'h12, r[25:16], 3'b000, r[12], r[11:0]}, pc);
        3: run("R6", {6'h12, r[25:16], 4'h8, r[11:0]}, pc);
        4: run("R7", {6'h12, r[25:16], (r[15:12] == 4'h0 || r[15:12] == 4'h1 ||
                                        r[15:12] == 4'h8) ? 4'h5 : r[15:12], r[11:0]}, pc);
        default: run("R8", {(r[31:26] inside {6'h0A, 6'h02, 6'h12}) ? 6'h3F : r[31:26],
                            r[25:0]}, pc);
      endcase
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule